// File: doc/BRIEF.md
# Ping-Pong LIFO Sample Reverser

This block turns an incoming stream of samples into a time-reversed copy, so that a symmetric filter can multiply the forward tap and its mirror tap with one coefficient. Two last-in-first-out stacks work as a pair. While one stack collects the incoming samples, the other one gives back the samples it collected earlier, newest first, on the reverse output. A falling transition on the transfer input swaps the two roles. A one-cycle forward delay stage runs alongside, so the forward and reverse samples leave the block in step.

The block has an active-low shift enable. That enable is registered first and then gates the forward register, the reverse register and both stacks. A sample is therefore taken at a clock edge only when the shift enable was low at the edge before. The stack depth is a parameter. A push to a full stack drops the sample. A pop from an empty stack gives zero.

Top module: `sym_tap_reverser`

## Requirements
- R1: While reset is active and after it is released, fwd_out and rev_out read 0, both stacks are empty, and stack 0 is the collecting stack.
- R2: The shift enable is registered. At a rising clock edge the datapath moves only when shift_en_n was sampled low at the edge before. When it moves, fwd_out takes the value of din.
- R3: At each moving edge, din is pushed onto the collecting stack, and rev_out takes the top of the other stack, which is popped. Samples therefore come back newest first.
- R4: The stacks swap roles at an edge where xfer is low and xfer was high at the edge before. The register that holds the previous value of xfer resets to 1.
- R5: Holding xfer low, holding it high, or a rising transition causes no swap. Each swap needs a new high-to-low transition.
- R6: At the edge where the swap is detected, the push and the pop still use the old roles. The new roles apply from the next edge on.
- R7: At an edge where the registered enable is inactive, fwd_out, rev_out and the contents of both stacks keep their values. A swap can still occur at such an edge.
- R8: A pop from an empty stack loads 0 into rev_out.
- R9: A push onto a stack that already holds DEPTH samples is dropped. The samples already in the stack are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | DATA_W (12) | Incoming sample |
| shift_en_n | input | 1 | Active-low shift enable, registered before use |
| xfer | input | 1 | Transfer control; a high-to-low transition swaps the stacks |
| fwd_out | output | DATA_W (12) | Forward path, din delayed by one moving edge |
| rev_out | output | DATA_W (12) | Reverse path, popped from the supplying stack |

## Verification
The bench fills one stack, swaps, and then drains it past empty. A design that did not reverse the order, or that gave back stale data after the last sample, shows the wrong sequence or a non-zero value. It holds xfer low over many edges, raises it, and toggles it while the enable is off. A design that swapped on the level of xfer, or on a rising transition, would keep swapping or drain the wrong stack. It also pushes past the depth, where a design that wrapped its pointer would lose the oldest samples. Finally it checks that the enable acts one cycle late; a design that used the enable without registering it moves the data one edge early.

// File: rtl/rev_pkg.sv
package rev_pkg;
  localparam int SAMPLE_W      = 12;
  localparam int DEFAULT_DEPTH = 8;

  // Which stack is currently collecting forward samples
  typedef enum logic {
    BANK_0 = 1'b0,
    BANK_1 = 1'b1
  } bank_e;
endpackage

// File: rtl/rev_ctrl.sv
module rev_ctrl
  import rev_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_en_n,
  input  logic  xfer,
  output logic  move,
  output bank_e collect
);
  logic  move_q, move_d;
  logic  xfer_q, xfer_d;
  bank_e coll_q, coll_d;
  logic  fall;

  always_comb begin
    fall   = xfer_q & ~xfer;
    move_d = ~shift_en_n;
    xfer_d = xfer;
    coll_d = coll_q;
    if (fall) coll_d = bank_e'(~coll_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      move_q <= 1'b0;
      xfer_q <= 1'b1;
      coll_q <= BANK_0;
    end else begin
      move_q <= move_d;
      xfer_q <= xfer_d;
      coll_q <= coll_d;
    end
  end

  assign move    = move_q;
  assign collect = coll_q;

  // R4: a role change is preceded by high-then-low on xfer
  assert_swap_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_q != $past(coll_q)) |-> ($past(xfer_q) && !$past(xfer)));

  // R5: xfer held low gives no further swap
  assert_no_swap_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_q && !xfer) |=> $stable(coll_q));

  // R5: a high level or rising transition gives no swap
  assert_no_swap_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> $stable(coll_q));
endmodule

// File: rtl/rev_lifo.sv
module rev_lifo #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign empty  = (ptr_q == '0);
  assign full   = (ptr_q == PTR_W'(DEPTH));
  assign wr_idx = IDX_W'(ptr_q);
  assign rd_idx = IDX_W'(ptr_q - PTR_W'(1));
  assign rdata  = empty ? '0 : mem[rd_idx];

  always_comb begin
    wr_en = 1'b0;
    ptr_d = ptr_q;
    if (push && !full) begin
      wr_en = 1'b1;
      ptr_d = ptr_q + PTR_W'(1);
    end else if (pop && !empty) begin
      ptr_d = ptr_q - PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wdata;
  end

  // R9: push on full leaves the fill level unchanged
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (ptr_q == PTR_W'(DEPTH)));

  // R8: pop on empty keeps the stack empty
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

  // R3: the ports never ask one stack to push and pop at once
  assert_one_role_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/sym_tap_reverser.sv
module sym_tap_reverser
  import rev_pkg::*;
#(
  parameter int DATA_W = SAMPLE_W,
  parameter int DEPTH  = DEFAULT_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              shift_en_n,
  input  logic              xfer,
  output logic [DATA_W-1:0] fwd_out,
  output logic [DATA_W-1:0] rev_out
);
  localparam int NBANK = 2;

  logic              move;
  bank_e             collect;
  logic [DATA_W-1:0] stk_rdata [NBANK];
  logic              stk_empty [NBANK];
  logic              stk_full  [NBANK];
  logic [DATA_W-1:0] fwd_q, fwd_d;
  logic [DATA_W-1:0] rev_q, rev_d;
  logic [DATA_W-1:0] pop_data;
  logic              pop_empty;

  rev_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_n (shift_en_n),
    .xfer       (xfer),
    .move       (move),
    .collect    (collect)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic is_coll;
    assign is_coll = (collect == bank_e'(b));
    rev_lifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (move & is_coll),
      .pop   (move & ~is_coll),
      .wdata (din),
      .rdata (stk_rdata[b]),
      .empty (stk_empty[b]),
      .full  (stk_full[b])
    );
  end

  always_comb begin
    pop_data  = (collect == BANK_0) ? stk_rdata[1] : stk_rdata[0];
    pop_empty = (collect == BANK_0) ? stk_empty[1] : stk_empty[0];
    fwd_d = fwd_q;
    rev_d = rev_q;
    if (move) begin
      fwd_d = din;
      rev_d = pop_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= '0;
      rev_q <= '0;
    end else begin
      fwd_q <= fwd_d;
      rev_q <= rev_d;
    end
  end

  assign fwd_out = fwd_q;
  assign rev_out = rev_q;

  // R7: idle edge holds both outputs
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !move |=> ($stable(fwd_out) && $stable(rev_out)));

  // R8: popping an empty stack yields zero
  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (move && pop_empty) |=> (rev_out == '0));

  // R2: moving edge captures din on the forward path
  assert_fwd_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> (fwd_out == $past(din)));

  // R1: stack 0 collects while reset is held
  assert_reset_bank_R1: assert property (@(posedge clk)
    !rst_n |-> (collect == BANK_0 && rev_out == '0 && fwd_out == '0));
endmodule

// File: tb/sym_tap_reverser_tb_top.sv
`timescale 1ns/1ps
module sym_tap_reverser_tb_top;
  localparam int W     = 12;
  localparam int DEPTH = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] din;
  logic         shift_en_n;
  logic         xfer;
  logic [W-1:0] fwd_out, rev_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state, built from the requirements
  int m_stk0[$];
  int m_stk1[$];
  int m_role;
  bit m_move;
  bit m_xprev;
  int m_fwd, m_rev;

  always #4 clk = ~clk;

  sym_tap_reverser #(.DATA_W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .shift_en_n(shift_en_n),
    .xfer(xfer), .fwd_out(fwd_out), .rev_out(rev_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_edge(input int d, input bit en_n, input bit x);
    if (m_move) begin
      m_fwd = d;
      if (m_role == 0) begin
        if (m_stk0.size() < DEPTH) m_stk0.push_back(d);
        m_rev = (m_stk1.size() > 0) ? m_stk1.pop_back() : 0;
      end else begin
        if (m_stk1.size() < DEPTH) m_stk1.push_back(d);
        m_rev = (m_stk0.size() > 0) ? m_stk0.pop_back() : 0;
      end
    end
    if (m_xprev && !x) m_role ^= 1;
    m_move  = !en_n;
    m_xprev = x;
  endtask

  // one clock: drive at negedge, compare after the rising edge
  task automatic step(input int d, input bit en_n, input bit x, input string tag);
    @(negedge clk);
    din = W'(d); shift_en_n = en_n; xfer = x;
    @(posedge clk);
    model_edge(d, en_n, x);
    #1;
    check({tag, " fwd"}, int'(fwd_out), m_fwd);
    check({tag, " rev"}, int'(rev_out), m_rev);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; din = '0; shift_en_n = 1'b1; xfer = 1'b1;
    m_stk0.delete(); m_stk1.delete();
    m_role = 0; m_move = 0; m_xprev = 1; m_fwd = 0; m_rev = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 fwd in reset", int'(fwd_out), 0);
    check("R1 rev in reset", int'(rev_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reverse();
    step(0, 0, 1, "R2 arm");
    for (int i = 1; i <= 5; i++) step(100 + i, 0, 1, "R3 fill");
    step(200, 0, 0, "R6 swap edge");
    for (int i = 0; i < 7; i++) step(300 + i, 0, 0, "R3 drain");
    step(400, 0, 0, "R8 empty pop");
  endtask

  task automatic t_swap_rules();
    step(500, 0, 1, "R5 rise");
    step(501, 0, 1, "R5 high");
    step(502, 0, 0, "R4 fall");
    for (int i = 0; i < 4; i++) step(510 + i, 0, 0, "R5 low hold");
    step(520, 0, 1, "R5 up");
    step(521, 0, 0, "R4 fall again");
    for (int i = 0; i < 6; i++) step(530 + i, 0, 0, "R3 after swap");
  endtask

  task automatic t_enable();
    step(600, 1, 0, "R2 disarm");
    step(601, 1, 0, "R7 idle");
    step(602, 1, 1, "R7 idle");
    step(603, 1, 0, "R7 swap while idle");
    step(604, 0, 0, "R2 enable late");
    step(605, 0, 0, "R2 moving");
    step(606, 1, 0, "R7 last move");
    step(607, 1, 0, "R7 held");
    for (int i = 0; i < 4; i++) step(610 + i, 0, 1, "R3 resume");
  endtask

  task automatic t_overflow();
    step(0, 0, 1, "R9 arm");
    step(1, 0, 0, "R4 flip");
    step(2, 0, 1, "R4 up");
    step(3, 0, 0, "R4 flip back");
    for (int i = 0; i < 12; i++) step(700 + i, 0, 0, "R8 drain");
    for (int i = 0; i < DEPTH + 4; i++) step(800 + i, 0, 1, "R9 overfill");
    step(900, 0, 0, "R6 swap");
    for (int i = 0; i < DEPTH + 3; i++) step(910 + i, 0, 0, "R9 drain");
  endtask

  initial begin
    do_reset();
    step(0, 1, 1, "R1 after release");
    t_reverse();
    t_swap_rules();
    t_enable();
    do_reset();
    t_overflow();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule